// File: doc/BRIEF.md
# Inner Label Ethertype Classifier

This block reads the inner label area of an encapsulated routing-bridge data frame one byte per accepted beat. The stream starts with the byte that follows the inner source MAC address, and a start marker travels with that byte. The first two bytes are an ethertype. They decide whether the frame carries a 12-bit VLAN tag or a 24-bit fine-grained label split into two tagged parts. Any other ethertype gives an "unknown" result.

The block finishes on the byte that decides the frame. It then presents the label kind, the 24-bit label value, the transit priority and the drop-eligible bit, together with a discard flag and a truncation status, and pulses a done strobe. Later bytes of the frame (the payload) pass through without effect. A separate counter reports how many bytes the current frame has supplied. The block never stalls its input.

Top module: `inner_label_classifier`

## Requirements
- R1: Label kind encoding: 00 VLAN, 01 fine-grained, 10 unknown, 11 malformed. An ethertype 0x8100 in bytes 0..1 (most significant byte first) gives kind 00 once byte 3 is accepted, with lbl_value = {12'h000, tag[11:0]}, where the tag is byte 2 (high) and byte 3 (low).
- R2: An ethertype 0x893B in bytes 0..1, with 0x893B again in bytes 4..5, gives kind 01 once byte 7 is accepted. lbl_value = {bytes2..3[11:0], bytes6..7[11:0]}.
- R3: If the first ethertype is 0x893B and bytes 4..5 are not 0x893B, the result is kind 11 with discard 1, trunc 0 and lbl_value 0, decided at byte 5. The remaining bytes of that frame have no effect.
- R4: For both the VLAN and the fine-grained result, xit_prio is bits [7:5] of byte 2 and xit_dei is bit 4 of byte 2. For the unknown and malformed results both are 0.
- R5: Any other first ethertype gives kind 10 with discard 0 and lbl_value 0, decided at byte 1. The remaining bytes of that frame have no effect.
- R6: If the end marker arrives on a byte before the deciding byte, the result is kind 11 with discard 1 and trunc 1. An end marker on the deciding byte itself is not a truncation.
- R7: done is high for exactly one cycle, the cycle after the deciding (or truncating) byte is accepted. All result outputs change at that same edge.
- R8: Result outputs hold from done until the next start-marked byte is accepted, which clears them to 0. Bytes accepted while no frame is open are ignored.
- R9: byte_cnt counts the accepted bytes from the start-marked byte through the end-marked byte inclusive. It is 1 after the start byte, holds after the end byte and saturates at its maximum.
- R10: After reset every output is 0 except in_ready, which is always 1.
- R11: A start-marked byte that arrives inside an open frame abandons that frame and begins a new parse from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte valid |
| in_ready | output | 1 | Always 1; the block accepts every byte |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Marks byte 0 of the label area |
| in_eof | input | 1 | Marks the last byte of the frame |
| lbl_kind | output | 2 | Result kind (00 VLAN, 01 fine, 10 unknown, 11 malformed) |
| lbl_value | output | 24 | Extracted label |
| xit_prio | output | 3 | Transit priority |
| xit_dei | output | 1 | Transit drop-eligible bit |
| discard | output | 1 | Frame must be dropped |
| trunc | output | 1 | Frame ended inside the label area |
| done | output | 1 | One-cycle result strobe |
| byte_cnt | output | CNT_W | Bytes accepted in the current frame |

## Verification
Two situations are the hardest to reach from the ports. The first is an end marker that lands on the exact byte that decides the frame, where a completed decision must win over truncation. The second is a start marker that arrives while a fine-grained label is only half read. Directed frames place the end marker on the deciding byte and on the byte before it, and they restart a frame at byte 2. Long runs of randomly built frames then add idle gaps, stray bytes between frames, and second ethertypes that are off by one bit. A behavioural byte-queue model in the bench is compared with every output on every cycle.

// File: rtl/lblc_pkg.sv
package lblc_pkg;
  localparam int LBL_BYTES = 8;

  typedef enum logic [1:0] {
    KIND_VLAN = 2'b00,
    KIND_FINE = 2'b01,
    KIND_UNKN = 2'b10,
    KIND_BAD  = 2'b11
  } lbl_kind_e;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'b00,
    PS_LABEL = 2'b01,
    PS_SKIP  = 2'b10
  } pos_st_e;

  typedef struct packed {
    lbl_kind_e   kind;
    logic [23:0] value;
    logic [2:0]  prio;
    logic        dei;
    logic        discard;
    logic        trunc;
  } lbl_res_t;

  function automatic logic [23:0] fine_join(input logic [15:0] hi, input logic [15:0] lo);
    return {hi[11:0], lo[11:0]};
  endfunction

  function automatic logic [23:0] vlan_widen(input logic [15:0] tag);
    return {12'h000, tag[11:0]};
  endfunction

  function automatic logic [2:0] part_prio(input logic [15:0] part);
    return part[15:13];
  endfunction

  function automatic logic part_dei(input logic [15:0] part);
    return part[12];
  endfunction

  function automatic lbl_res_t res_clear();
    lbl_res_t r;
    r = '0;
    return r;
  endfunction

  function automatic lbl_res_t res_fault(input logic cut);
    lbl_res_t r;
    r = '0;
    r.kind    = KIND_BAD;
    r.discard = 1'b1;
    r.trunc   = cut;
    return r;
  endfunction
endpackage

// File: rtl/lblc_pos.sv
module lblc_pos
  import lblc_pkg::*;
#(
  parameter int POS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             sof,
  input  logic             eof,
  input  logic             fin,
  output logic             in_label,
  output logic             open_now,
  output logic [POS_W-1:0] epos
);
  pos_st_e          st_q;
  logic [POS_W-1:0] pos_q;

  assign in_label = sof | (st_q == PS_LABEL);
  assign open_now = sof | (st_q != PS_IDLE);
  assign epos     = sof ? '0 : pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_IDLE;
      pos_q <= '0;
    end else if (take) begin
      if (in_label) begin
        if (eof) begin
          st_q <= PS_IDLE;
        end else if (fin) begin
          st_q <= PS_SKIP;
        end else begin
          st_q  <= PS_LABEL;
          pos_q <= epos + 1'b1;
        end
      end else if (open_now && eof) begin
        st_q <= PS_IDLE;
      end
    end
  end
endmodule

// File: rtl/lblc_cap.sv
module lblc_cap #(
  parameter int SLOTS = 7,
  parameter int POS_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [POS_W-1:0]      epos,
  input  logic [7:0]            din,
  output logic [SLOTS-1:0][7:0] cap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap <= '0;
    end else if (wr) begin
      for (int k = 0; k < SLOTS; k++) begin
        if (epos == POS_W'(k)) cap[k] <= din;
      end
    end
  end
endmodule

// File: rtl/lblc_decide.sv
module lblc_decide
  import lblc_pkg::*;
#(
  parameter int          SLOTS   = 7,
  parameter int          POS_W   = 3,
  parameter logic [15:0] VLAN_ET = 16'h8100,
  parameter logic [15:0] FINE_ET = 16'h893B
) (
  input  logic [POS_W-1:0]      epos,
  input  logic [7:0]            din,
  input  logic [SLOTS-1:0][7:0] cap,
  input  logic                  eof,
  output logic                  fin,
  output logic                  cut,
  output lbl_res_t              res
);
  logic [15:0] et_live, et_held, part_a_live, part_a_held, et2_live, part_b_live;

  assign et_live     = {cap[0], din};
  assign et_held     = {cap[0], cap[1]};
  assign part_a_live = {cap[2], din};
  assign part_a_held = {cap[2], cap[3]};
  assign et2_live    = {cap[4], din};
  assign part_b_live = {cap[6], din};

  always_comb begin
    fin = 1'b0;
    res = res_clear();
    case (epos)
      POS_W'(1): if (et_live != VLAN_ET && et_live != FINE_ET) begin
        fin      = 1'b1;
        res.kind = KIND_UNKN;
      end
      POS_W'(3): if (et_held == VLAN_ET) begin
        fin       = 1'b1;
        res.kind  = KIND_VLAN;
        res.value = vlan_widen(part_a_live);
        res.prio  = part_prio(part_a_live);
        res.dei   = part_dei(part_a_live);
      end
      POS_W'(5): if (et2_live != FINE_ET) begin
        fin = 1'b1;
        res = res_fault(1'b0);
      end
      POS_W'(7): begin
        fin       = 1'b1;
        res.kind  = KIND_FINE;
        res.value = fine_join(part_a_held, part_b_live);
        res.prio  = part_prio(part_a_held);
        res.dei   = part_dei(part_a_held);
      end
      default: ;
    endcase
    cut = eof & ~fin;
    if (cut) res = res_fault(1'b1);
  end
endmodule

// File: rtl/lblc_bcnt.sv
module lblc_bcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             sof,
  input  logic             open_now,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (take) begin
      if (sof) cnt <= CNT_W'(1);
      else if (open_now && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/inner_label_classifier.sv
module inner_label_classifier
  import lblc_pkg::*;
#(
  parameter int          CNT_W   = 16,
  parameter logic [15:0] VLAN_ET = 16'h8100,
  parameter logic [15:0] FINE_ET = 16'h893B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic [1:0]       lbl_kind,
  output logic [23:0]      lbl_value,
  output logic [2:0]       xit_prio,
  output logic             xit_dei,
  output logic             discard,
  output logic             trunc,
  output logic             done,
  output logic [CNT_W-1:0] byte_cnt
);
  localparam int POS_W = $clog2(LBL_BYTES);
  localparam int SLOTS = LBL_BYTES - 1;

  logic                  take, in_label, open_now, fin_now, cut_now, commit;
  logic [POS_W-1:0]      epos;
  logic [SLOTS-1:0][7:0] cap;
  lbl_res_t              res_now, res_q;

  assign in_ready = 1'b1;
  assign take     = in_valid & in_ready;
  assign commit   = take & in_label & (fin_now | cut_now);

  lblc_pos #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .take(take), .sof(in_sof), .eof(in_eof),
    .fin(fin_now), .in_label(in_label), .open_now(open_now), .epos(epos)
  );

  lblc_cap #(.SLOTS(SLOTS), .POS_W(POS_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .wr(take & in_label), .epos(epos),
    .din(in_data), .cap(cap)
  );

  lblc_decide #(.SLOTS(SLOTS), .POS_W(POS_W), .VLAN_ET(VLAN_ET), .FINE_ET(FINE_ET)) u_decide (
    .epos(epos), .din(in_data), .cap(cap), .eof(in_eof),
    .fin(fin_now), .cut(cut_now), .res(res_now)
  );

  lblc_bcnt #(.CNT_W(CNT_W)) u_bcnt (
    .clk(clk), .rst_n(rst_n), .take(take), .sof(in_sof),
    .open_now(open_now), .cnt(byte_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= res_clear();
      done  <= 1'b0;
    end else begin
      done <= commit;
      if (commit) res_q <= res_now;
      else if (take && in_sof) res_q <= res_clear();
    end
  end

  assign lbl_kind  = res_q.kind;
  assign lbl_value = res_q.value;
  assign xit_prio  = res_q.prio;
  assign xit_dei   = res_q.dei;
  assign discard   = res_q.discard;
  assign trunc     = res_q.trunc;
endmodule

// File: rtl/lblc_chk.sv
module lblc_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             take,
  input logic             sof,
  input logic             commit,
  input logic             done,
  input logic [1:0]       kind,
  input logic [23:0]      value,
  input logic             discard,
  input logic             trunc,
  input logic [CNT_W-1:0] byte_cnt
);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_discard_bad: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (discard == (kind == 2'b11)));

  a_r6_trunc_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (done && trunc) |-> (discard && kind == 2'b11));

  a_r1_vlan_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == 2'b00) |-> (value[23:12] == 12'h000));

  a_r5_unknown_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == 2'b10) |-> (!discard && value == 24'h0));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !(take && sof)) |=> ($stable(value) && $stable(kind) && $stable(discard) && $stable(trunc)));

  a_r9_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sof) |=> (byte_cnt == CNT_W'(1)));
endmodule

bind inner_label_classifier lblc_chk #(.CNT_W(CNT_W)) u_lblc_chk (
  .clk(clk), .rst_n(rst_n), .take(take), .sof(in_sof), .commit(commit),
  .done(done), .kind(lbl_kind), .value(lbl_value), .discard(discard),
  .trunc(trunc), .byte_cnt(byte_cnt)
);

// File: tb/test_inner_label_classifier.sv
`timescale 1ns/1ps
module test_inner_label_classifier;
  localparam int CNT_W = 16;
  localparam int CMAX  = 65535;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, xit_dei, discard, trunc, done;
  logic [1:0] lbl_kind;
  logic [23:0] lbl_value;
  logic [2:0] xit_prio;
  logic [CNT_W-1:0] byte_cnt;

  int checks = 0, fails = 0, cyc = 0;
  bit started = 0, finished = 0;

  always #2 clk = ~clk;

  inner_label_classifier #(.CNT_W(CNT_W)) i_inner_label_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .lbl_kind(lbl_kind),
    .lbl_value(lbl_value), .xit_prio(xit_prio), .xit_dei(xit_dei),
    .discard(discard), .trunc(trunc), .done(done), .byte_cnt(byte_cnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: bytes of the open label area kept in a queue
  bit [7:0] q[$];
  bit m_open = 0, m_lab = 0;
  int m_cnt = 0, e_kind = 0, e_val = 0, e_prio = 0, e_dei = 0, e_disc = 0, e_trunc = 0, e_done = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q.delete(); m_open = 0; m_lab = 0; m_cnt = 0;
      e_kind = 0; e_val = 0; e_prio = 0; e_dei = 0; e_disc = 0; e_trunc = 0; e_done = 0;
    end else begin
      e_done = 0;
      if (in_valid) begin
        if (in_sof) begin
          q.delete(); m_open = 1; m_lab = 1; m_cnt = 0;
          e_kind = 0; e_val = 0; e_prio = 0; e_dei = 0; e_disc = 0; e_trunc = 0;
        end
        if (m_open) m_cnt = (m_cnt < CMAX) ? m_cnt + 1 : CMAX;
        if (m_lab) begin
          int n, et1, et2, hi, lo;
          bit fin;
          q.push_back(in_data);
          n = q.size(); fin = 0;
          et1 = (n >= 2) ? int'(q[0]) * 256 + int'(q[1]) : 0;
          if (n == 2 && et1 != 'h8100 && et1 != 'h893B) begin
            fin = 1; e_kind = 2;
          end else if (n == 4 && et1 == 'h8100) begin
            hi = int'(q[2]) * 256 + int'(q[3]);
            fin = 1; e_kind = 0; e_val = hi % 4096; e_prio = hi / 8192; e_dei = (hi / 4096) % 2;
          end else if (n == 6) begin
            et2 = int'(q[4]) * 256 + int'(q[5]);
            if (et2 != 'h893B) begin fin = 1; e_kind = 3; e_disc = 1; end
          end else if (n == 8) begin
            hi = int'(q[2]) * 256 + int'(q[3]);
            lo = int'(q[6]) * 256 + int'(q[7]);
            fin = 1; e_kind = 1; e_val = (hi % 4096) * 4096 + lo % 4096;
            e_prio = hi / 8192; e_dei = (hi / 4096) % 2;
          end
          if (!fin && in_eof) begin fin = 1; e_kind = 3; e_disc = 1; e_trunc = 1; end
          if (fin) begin e_done = 1; m_lab = 0; end
        end
        if (in_eof) begin m_open = 0; m_lab = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R7 done", int'(done), e_done);
      chk("R1 kind", int'(lbl_kind), e_kind);
      chk("R2 value", int'(lbl_value), e_val);
      chk("R4 prio", int'(xit_prio), e_prio);
      chk("R4 dei", int'(xit_dei), e_dei);
      chk("R3 discard", int'(discard), e_disc);
      chk("R6 trunc", int'(trunc), e_trunc);
      chk("R9 byte_cnt", int'(byte_cnt), m_cnt);
      chk("R10 in_ready", int'(in_ready), 1);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic put(input bit [7:0] b, input bit s, input bit e);
    @(negedge clk);
    in_valid = 1; in_data = b; in_sof = s; in_eof = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eof = 0; in_data = 8'h00;
    end
  endtask

  task automatic send(input bit [7:0] f[$], input bit close, input bit gaps);
    for (int i = 0; i < f.size(); i++) begin
      if (gaps && $urandom_range(0, 3) == 0) idle(1);
      put(f[i], i == 0, close && (i == f.size() - 1));
    end
    idle(1);
  endtask

  function automatic bit [7:0] rb();
    return 8'($urandom_range(0, 255));
  endfunction

  task automatic rnd_frame();
    bit [7:0] f[$];
    int sel = $urandom_range(0, 6);
    int plen = $urandom_range(0, 3);
    bit close = 1;
    case (sel)
      0: f = '{8'h81, 8'h00, rb(), rb()};
      1: f = '{8'h89, 8'h3B, rb(), rb(), 8'h89, 8'h3B, rb(), rb()};
      2: f = '{8'h89, 8'h3B, rb(), rb(), 8'h89, 8'h3B ^ (8'h01 << $urandom_range(0, 7)), rb(), rb()};
      3: f = '{8'h08, rb(), rb(), rb()};
      4: begin
        f = '{8'h89, 8'h3B, rb(), rb(), 8'h89, 8'h3B, rb()};
        while (f.size() > $urandom_range(1, 7)) void'(f.pop_back());
        plen = 0;
      end
      5: f = '{8'h89, 8'h3B, rb(), rb(), rb(), rb(), rb(), rb()};
      default: begin f = '{8'h89, 8'h3B, rb()}; close = 0; plen = 0; end
    endcase
    for (int i = 0; i < plen; i++) f.push_back(rb());
    send(f, close, 1);
    if ($urandom_range(0, 4) == 0) begin
      put(rb(), 0, $urandom_range(0, 1) == 1);  // stray byte, no frame open (R8)
      idle(1);
    end
  endtask

  initial begin
    idle(2);
    started = 1;
    idle(1);
    rst_n = 1;
    idle(1);
    // R10: reset state
    chk("R10 kind after reset", int'(lbl_kind), 0);
    chk("R10 done after reset", int'(done), 0);
    chk("R10 byte_cnt after reset", int'(byte_cnt), 0);

    // R1/R4: VLAN frame, tag 0xB567 -> prio 5, dei 1, label 0x567
    send('{8'h81, 8'h00, 8'hB5, 8'h67, 8'hDE, 8'hAD}, 1, 0);
    chk("R1 vlan kind", int'(lbl_kind), 0);
    chk("R1 vlan value", int'(lbl_value), 'h000567);
    chk("R4 vlan prio", int'(xit_prio), 5);
    chk("R4 vlan dei", int'(xit_dei), 1);
    chk("R9 vlan count", int'(byte_cnt), 6);

    // R2/R4: fine frame, parts 0x6ABC / 0x2DEF -> 0xABCDEF, prio 3
    send('{8'h89, 8'h3B, 8'h6A, 8'hBC, 8'h89, 8'h3B, 8'h2D, 8'hEF, 8'h11}, 1, 0);
    chk("R2 fine kind", int'(lbl_kind), 1);
    chk("R2 fine value", int'(lbl_value), 'hABCDEF);
    chk("R4 fine prio", int'(xit_prio), 3);
    chk("R9 fine count", int'(byte_cnt), 9);

    // R3: wrong second ethertype
    send('{8'h89, 8'h3B, 8'h6A, 8'hBC, 8'h81, 8'h00, 8'h2D, 8'hEF}, 1, 0);
    chk("R3 bad kind", int'(lbl_kind), 3);
    chk("R3 bad discard", int'(discard), 1);
    chk("R3 bad trunc", int'(trunc), 0);
    chk("R3 bad value", int'(lbl_value), 0);

    // R5: unknown ethertype
    send('{8'h08, 8'h00, 8'h45, 8'h00}, 1, 0);
    chk("R5 unknown kind", int'(lbl_kind), 2);
    chk("R5 unknown discard", int'(discard), 0);

    // R6: truncation one byte early, then end on the deciding byte
    send('{8'h81, 8'h00, 8'hB5}, 1, 0);
    chk("R6 cut kind", int'(lbl_kind), 3);
    chk("R6 cut trunc", int'(trunc), 1);
    send('{8'h81, 8'h00, 8'hB5, 8'h67}, 1, 0);
    chk("R6 exact end kind", int'(lbl_kind), 0);
    chk("R6 exact end trunc", int'(trunc), 0);
    send('{8'h81}, 1, 0);
    chk("R6 single byte trunc", int'(trunc), 1);
    chk("R9 single byte count", int'(byte_cnt), 1);

    // R8: stray bytes with no frame open change nothing
    put(8'h89, 0, 0); put(8'h3B, 0, 1); idle(2);
    chk("R8 stray kind", int'(lbl_kind), 3);
    chk("R8 stray count", int'(byte_cnt), 1);

    // R11: restart inside a half-read fine label
    send('{8'h89, 8'h3B, 8'h11}, 0, 0);
    send('{8'h81, 8'h00, 8'h0F, 8'hFF}, 1, 0);
    chk("R11 restart kind", int'(lbl_kind), 0);
    chk("R11 restart value", int'(lbl_value), 'hFFF);
    chk("R11 restart count", int'(byte_cnt), 4);

    for (int k = 0; k < 600; k++) rnd_frame();
    idle(3);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule